// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable model of a flow-through static RAM whose data bus never needs an idle cycle when traffic turns from reads to writes or back. Each rising clock edge samples an address together with its control inputs. The data that belongs to that operation moves in the following cycle. For a read, the data word appears combinationally from the array during that cycle. For a write, the data is captured at the next edge. Because both kinds of operation put their data in the same slot behind the address, reads and writes can alternate on every cycle.

A single address can start a four-beat burst. The two low address bits then advance either by simple increment modulo four or by XOR with the beat count, and the upper bits stay fixed. Writes are masked per 9-bit lane. An active-low clock enable freezes the whole block. Three chip selects allow depth expansion. An asynchronous output enable can silence the read drivers. The shared bus is split into `din`, `dout` and `dout_oe`, so bus ownership is visible on every cycle.

Top module: `zt_sram`

## Requirements
- R1: With `cken_n` low, a load cycle (`adv`=0, all chip selects active) with `rd_wr`=1 reads `addr`. In the next cycle `dout_oe` is 1 and `dout` holds the stored word at that address.
- R2: A load cycle with `rd_wr`=0 writes `addr` with the `din` value present at the following edge. Lane i (bits 9i+8..9i) is written only when `lane_wen_n[i]` is 0 at the address cycle. `lane_wen_n` has no effect on reads.
- R3: Reads and writes may follow each other on consecutive cycles with no idle cycle. A read issued in the cycle right after a write to the same address returns the newly written data.
- R4: An `adv`=1 cycle during an active burst issues the next beat. The beat keeps the read/write type of its load cycle, samples `lane_wen_n` again, and keeps the upper address bits. The beat count wraps modulo 4.
- R5: With `interleave`=0 the low two address bits of beat k are (start+k) mod 4.
- R6: With `interleave`=1 the low two address bits of beat k are start XOR k.
- R7: The part is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A load cycle with any select inactive starts no operation and ends any burst. Later `adv`=1 cycles issue nothing until the next selected load.
- R8: A write whose address cycle has already passed completes even when the next cycle deselects the part.
- R9: `dout_oe` is 0 in the cycle after a write address cycle, and in the cycle after a deselecting load cycle.
- R10: While `cken_n` is 1, all synchronous inputs are ignored and every register holds. A pending read keeps being driven. A pending write commits at the next edge where `cken_n` is 0, using `din` from that edge.
- R11: `oe_n`=1 forces `dout_oe` to 0 at once, without waiting for a clock edge.
- R12: While `rst_n` is low and after it is released, no operation is pending, no burst is active, and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cken_n | input | 1 | Active-low clock enable; high suspends everything |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new address, 1 steps the burst |
| rd_wr | input | 1 | 1 read, 0 write (load cycles only) |
| addr | input | ADDR_W | Word address |
| lane_wen_n | input | LANES | Active-low per-lane write enables |
| interleave | input | 1 | Burst order: 0 linear, 1 XOR |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, one cycle behind its address |
| dout | output | LANES*LANE_W | Read data, one cycle behind its address |
| dout_oe | output | 1 | High when the block drives the bus |

## Verification
A corrupted burst counter or base register shows on `dout` at the very next beat as a word from the wrong address, because each beat is read from the array in its own cycle. A wrong pending-operation type or a stale valid flag shows within one cycle as `dout_oe` asserted during a write or after a deselect. A write committed to the wrong lanes or address stays hidden until that address is read back, so the bench reads back every written location, often in the very next cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } zt_op_t;

  // Low two address bits for a burst beat.
  function automatic logic [1:0] zt_beat_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       xor_order);
    logic [1:0] res;
    if (xor_order) res = start ^ beat;
    else           res = start + beat;
    return res;
  endfunction

  function automatic zt_op_t zt_op_of(input logic rd_wr);
    return rd_wr ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/zt_burst_ctrl.sv
module zt_burst_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken_n,
  input  logic              chip_sel,
  input  logic              adv,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wen_n,
  input  logic              interleave,
  output logic              req_valid,
  output zt_op_t            req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LANES-1:0]  req_wen_n
);

  localparam int HI_W = ADDR_W - 2;

  logic              burst_on;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  zt_op_t            op_q;

  // named events
  logic       clk_go;
  logic       load_hit;
  logic       load_miss;
  logic       beat_step;
  logic [1:0] beat_nxt;
  logic [1:0] low_nxt;

  assign clk_go    = !cken_n;
  assign load_hit  = !adv && chip_sel;
  assign load_miss = !adv && !chip_sel;
  assign beat_step = adv && burst_on;
  assign beat_nxt  = beat_q + 2'd1;
  assign low_nxt   = zt_beat_low(base_q[1:0], beat_nxt, interleave);

  always_comb begin
    req_valid = load_hit || beat_step;
    req_wen_n = lane_wen_n;
    if (load_hit) begin
      req_op   = zt_op_of(rd_wr);
      req_addr = addr;
    end else begin
      req_op   = op_q;
      req_addr = {base_q[ADDR_W-1 -: HI_W], low_nxt};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
      op_q     <= OP_READ;
    end else if (clk_go) begin
      if (load_hit) begin
        burst_on <= 1'b1;
        base_q   <= addr;
        beat_q   <= 2'd0;
        op_q     <= zt_op_of(rd_wr);
      end else if (load_miss) begin
        burst_on <= 1'b0;
      end else if (beat_step) begin
        beat_q <= beat_nxt;
      end
    end
  end

  assert_beat_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_go && beat_step) |=> (beat_q == $past(beat_q) + 2'd1));

  assert_burst_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_go && load_miss) |=> !burst_on);

  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cken_n |=> ($stable(beat_q) && $stable(burst_on) && $stable(base_q)));

endmodule

// File: rtl/zt_data_stage.sv
module zt_data_stage
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken_n,
  input  logic              req_valid,
  input  zt_op_t            req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_wen_n,
  output logic              pend_valid,
  output zt_op_t            pend_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_wen_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_op    <= OP_READ;
      pend_addr  <= '0;
      pend_wen_n <= '1;
    end else if (!cken_n) begin
      pend_valid <= req_valid;
      pend_op    <= req_op;
      pend_addr  <= req_addr;
      pend_wen_n <= req_wen_n;
    end
  end

  assert_stage_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cken_n |=> ($stable(pend_valid) && $stable(pend_addr) && $stable(pend_op)));

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_go,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic              lane_we;

    assign lane_we = wr_go && wr_lane[g];

    always_ff @(posedge clk) begin
      if (lane_we) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cken_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    adv,
  input  logic                    rd_wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wen_n,
  input  logic                    interleave,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe
);

  logic              chip_sel;
  logic              req_valid;
  zt_op_t            req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [LANES-1:0]  req_wen_n;
  logic              pend_valid;
  zt_op_t            pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_wen_n;

  // named events
  logic commit_wr;
  logic read_phase;

  assign chip_sel   = !cs_a_n && cs_b && !cs_c_n;
  assign commit_wr  = !cken_n && pend_valid && (pend_op == OP_WRITE);
  assign read_phase = pend_valid && (pend_op == OP_READ);
  assign dout_oe    = read_phase && !oe_n;

  zt_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .chip_sel(chip_sel),
    .adv(adv), .rd_wr(rd_wr), .addr(addr), .lane_wen_n(lane_wen_n),
    .interleave(interleave), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wen_n(req_wen_n)
  );

  zt_data_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) stage_i (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_wen_n(req_wen_n),
    .pend_valid(pend_valid), .pend_op(pend_op), .pend_addr(pend_addr),
    .pend_wen_n(pend_wen_n)
  );

  zt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .wr_go(commit_wr), .wr_addr(pend_addr), .wr_lane(~pend_wen_n),
    .wr_data(din), .rd_addr(pend_addr), .rd_data(dout)
  );

  assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && chip_sel) |=> (pend_valid && pend_addr == $past(addr)));

  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && chip_sel && !rd_wr) |=> !dout_oe);

  assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && !chip_sel) |=> !dout_oe);

  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |-> !dout_oe);

endmodule

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cken_n = 1'b0;
  logic        cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic        adv = 1'b0, rd_wr = 1'b1;
  logic [5:0]  addr = '0;
  logic [3:0]  lane_wen_n = '1;
  logic        interleave = 1'b0;
  logic        oe_n = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_oe;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R12";
  int salt = 0;

  // reference model state
  logic [35:0] mref [64];
  bit          m_pv, m_pw, m_burst, m_bw;
  int          m_pa, m_base, m_cnt;
  logic [3:0]  m_pm;

  always #2.5 clk = ~clk;

  zt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .adv(adv), .rd_wr(rd_wr), .addr(addr),
    .lane_wen_n(lane_wen_n), .interleave(interleave), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [35:0] pat(int a, int s);
    return {4'(s), 8'(a), 24'(a * 40503 + s * 7919 + 17)};
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit sel;
    int low;
    if (!rst_n) begin
      m_pv = 0; m_burst = 0;
    end else if (!cken_n) begin
      if (m_pv && m_pw)
        for (int l = 0; l < 4; l++)
          if (!m_pm[l]) mref[m_pa][l*9 +: 9] = din[l*9 +: 9];
      sel = !cs_a_n && cs_b && !cs_c_n;
      if (!adv) begin
        if (sel) begin
          m_burst = 1; m_base = int'(addr); m_cnt = 0; m_bw = !rd_wr;
          m_pv = 1; m_pw = !rd_wr; m_pa = int'(addr); m_pm = lane_wen_n;
        end else begin
          m_burst = 0; m_pv = 0;
        end
      end else if (m_burst) begin
        m_cnt = (m_cnt + 1) % 4;
        low = interleave ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        m_pa = (m_base / 4) * 4 + low;
        m_pv = 1; m_pw = m_bw; m_pm = lane_wen_n;
      end else begin
        m_pv = 0;
      end
    end
  endtask

  task automatic compare();
    bit exp_oe;
    exp_oe = rst_n && m_pv && !m_pw && !oe_n;
    check(cur_req, 36'(dout_oe), 36'(exp_oe), "dout_oe");
    if (exp_oe) check(cur_req, dout, mref[m_pa], "dout");
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    if (m_pv && m_pw) din = pat(m_pa, salt);
    else              din = 36'h5_A5A5_A5A5;
  endtask

  task automatic go(bit a_adv, bit a_rd, int a_addr, logic [3:0] m);
    cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    adv = a_adv; rd_wr = a_rd; addr = 6'(a_addr); lane_wen_n = m;
    tick();
  endtask

  task automatic desel(int which);
    adv = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    case (which)
      0: cs_a_n = 1;
      1: cs_b = 0;
      default: cs_c_n = 1;
    endcase
    tick();
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R12: reset state
    cur_req = "R12";
    #1;
    check("R12", 36'(dout_oe), 36'd0, "dout_oe in reset");
    repeat (3) tick();
    rst_n = 1;
    desel(1);
    check("R12", 36'(dout_oe), 36'd0, "dout_oe after reset");

    // R5 + R4: fill whole array with linear write bursts
    cur_req = "R5"; interleave = 0; salt = 1;
    for (int b = 0; b < 16; b++) begin
      go(0, 0, 4 * b, 4'b0000);
      for (int k = 0; k < 3; k++) go(1, 0, 0, 4'b0000);
    end
    desel(1);

    // R1: single reads back to back
    cur_req = "R1";
    for (int a = 0; a < 10; a++) go(0, 1, a, 4'b0000);
    desel(0);

    // R5: linear burst read from misaligned start
    cur_req = "R5";
    go(0, 1, 6, 4'b1111);
    for (int k = 0; k < 5; k++) go(1, 0, 0, 4'b1111);

    // R3: write then immediately read same address
    cur_req = "R3"; salt = 2;
    for (int a = 20; a < 28; a++) begin
      go(0, 0, a, 4'b0000);
      go(0, 1, a, 4'b0000);
    end
    desel(2);

    // R2: lane masks, ignored on reads
    cur_req = "R2"; salt = 3;
    go(0, 0, 30, 4'b1010);
    go(0, 1, 30, 4'b0000);
    go(0, 0, 40, 4'b0001);
    go(1, 1, 0, 4'b0010);
    go(1, 1, 0, 4'b0100);
    go(1, 1, 0, 4'b1000);
    go(0, 1, 40, 4'b0000);
    for (int k = 0; k < 3; k++) go(1, 0, 0, 4'b0000);
    go(0, 1, 30, 4'b0000);
    desel(1);

    // R6: interleaved order
    cur_req = "R6"; interleave = 1; salt = 4;
    go(0, 1, 45, 4'b0000);
    for (int k = 0; k < 3; k++) go(1, 1, 0, 4'b0000);
    go(0, 0, 50, 4'b0000);
    for (int k = 0; k < 3; k++) go(1, 1, 0, 4'b0000);
    interleave = 0;
    go(0, 1, 48, 4'b0000);
    for (int k = 0; k < 3; k++) go(1, 1, 0, 4'b0000);
    interleave = 1;
    go(0, 1, 51, 4'b0000);
    for (int k = 0; k < 3; k++) go(1, 1, 0, 4'b0000);
    interleave = 0;

    // R7: each select stops a burst; advance then does nothing
    cur_req = "R7";
    for (int w = 0; w < 3; w++) begin
      go(0, 1, 8 + w, 4'b0000);
      go(1, 1, 0, 4'b0000);
      desel(w);
      go(1, 1, 0, 4'b0000);
      go(1, 0, 0, 4'b0000);
      check("R7", 36'(dout_oe), 36'd0, "no beat after deselect");
    end

    // R8 + R9: pending write completes across deselect
    cur_req = "R8"; salt = 5;
    go(0, 0, 60, 4'b0000);
    check("R9", 36'(dout_oe), 36'd0, "quiet after write");
    desel(1);
    check("R9", 36'(dout_oe), 36'd0, "quiet after deselect");
    go(0, 1, 60, 4'b0000);
    check("R8", dout, pat(60, 5), "write committed across deselect");
    desel(0);

    // R10: suspend during read burst and during pending write
    cur_req = "R10"; salt = 6;
    go(0, 1, 12, 4'b0000);
    go(1, 1, 0, 4'b0000);
    cken_n = 1;
    for (int k = 0; k < 3; k++) go(0, 0, 1, 4'b0000);
    cken_n = 0;
    go(1, 1, 0, 4'b0000);
    go(1, 1, 0, 4'b0000);
    go(0, 0, 33, 4'b0000);
    cken_n = 1;
    go(0, 1, 2, 4'b0000);
    go(1, 1, 0, 4'b0000);
    cken_n = 0;
    go(0, 1, 33, 4'b0000);
    check("R10", dout, pat(33, 6), "suspended write commit");
    desel(1);

    // R11: asynchronous output enable
    cur_req = "R11";
    go(0, 1, 3, 4'b0000);
    oe_n = 1; #0.5;
    check("R11", 36'(dout_oe), 36'd0, "oe_n forces off");
    oe_n = 0; #0.5;
    check("R11", 36'(dout_oe), 36'd1, "oe_n released");
    oe_n = 1;
    go(1, 1, 0, 4'b0000);
    oe_n = 0;
    go(1, 1, 0, 4'b0000);
    desel(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule